// File: doc/BRIEF.md
# Metering Sample Conditioning Chain

This block sits after the decimation stage of a single-phase energy meter. Every time the decimator delivers a set of three 24-bit two's complement samples (phase current, neutral current and line voltage, typically about 6.99 thousand sets per second), it conditions them and delivers the three results together two clock cycles later under one valid strobe.

Each channel first passes an optional DC-blocking high-pass filter. One shared enable bit turns the filter on or off for all three channels at once. The two current channels then pass an optional leaky integrator, which restores a signal proportional to current when the sensor reports its rate of change. Each current channel has its own integrator enable. The voltage channel has no integrator.

A small configuration register holds the three enable bits. A disabled stage still spends its register stage, so all channels stay sample-aligned whatever the configuration.

Top module: `meter_cond_chain`

## Requirements
- R1: After reset, every sample output is 0, `out_valid` is 0, the high-pass filter is enabled and both integrators are disabled.
- R2: For each cycle with `in_valid` high, `out_valid` is high for exactly one cycle, two cycles later, whatever the configuration. The outputs hold their value while `out_valid` is low.
- R3: With the filter enabled, each channel keeps a state s that starts at 0 and a previous input p that starts at 0. Per sample x it computes s' = s + ((x - p) << 8) - (s >>> 9), then outputs s' >>> 8 saturated to [-8388608, 8388607].
- R4: A constant input on any channel, with the filter enabled, drives that output to within ±2 of zero after 9000 samples.
- R5: With configuration bit 2 at 0, the filter stage passes each sample unchanged and clears its state s. The previous input p keeps tracking the input.
- R6: With configuration bit 0 at 1, the phase-current channel integrates. Its accumulator a (initially 0) becomes a' = sat(a - (a >>> 8) + h), where h is the filter-stage value, and the output is a'.
- R7: Configuration bit 1 enables the same integrator on the neutral-current channel, independently of bit 0.
- R8: The integrator saturates at 8388607 and -8388608 and never wraps.
- R9: A disabled integrator passes the filter-stage value unchanged and clears its accumulator, so that it restarts from 0 when enabled again.
- R10: The voltage output never integrates, whatever the values of bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 3 | Bit 0: phase integrator, bit 1: neutral integrator, bit 2: high-pass filter |
| in_valid | input | 1 | A new sample set is present |
| ia_in | input | 24 | Phase-current sample, two's complement |
| ib_in | input | 24 | Neutral-current sample, two's complement |
| v_in | input | 24 | Voltage sample, two's complement |
| out_valid | output | 1 | Conditioned sample set is present |
| ia_out | output | 24 | Conditioned phase-current sample |
| ib_out | output | 24 | Conditioned neutral-current sample |
| v_out | output | 24 | Conditioned voltage sample |

## Verification
A long constant input with different levels per channel is used to show DC removal and the exact filter recursion. Alternating full-scale steps reach the filter's output clamp. Pseudo-random data with the filter disabled separates true pass-through from a filter that only settles. Held constant inputs with the integrators enabled in turn show that each current channel integrates on its own, that both rails saturate and that the voltage channel never integrates. Sparse and back-to-back valid patterns show the fixed two-cycle alignment and the holding of outputs between samples.

// File: rtl/meter_cond_pkg.sv
package meter_cond_pkg;

    localparam int SAMPLE_W = 24;
    localparam int WIDE_W   = 48;
    localparam int NUM_CH   = 3;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [WIDE_W-1:0]   wide_t;

    typedef enum int {
        CH_IA = 0,
        CH_IB = 1,
        CH_V  = 2
    } chan_idx_e;

    // bit 2 filter enable, bit 1 neutral integrator, bit 0 phase integrator
    typedef struct packed {
        logic hpf_en;
        logic int_b_en;
        logic int_a_en;
    } cond_cfg_t;

    localparam cond_cfg_t CFG_RESET = '{hpf_en: 1'b1, int_b_en: 1'b0, int_a_en: 1'b0};

    localparam wide_t WIDE_MAX = (wide_t'(1) <<< (SAMPLE_W - 1)) - wide_t'(1);
    localparam wide_t WIDE_MIN = -(wide_t'(1) <<< (SAMPLE_W - 1));

    function automatic sample_t sat_to_sample(input wide_t v);
        if (v > WIDE_MAX)
            return sample_t'(WIDE_MAX[SAMPLE_W-1:0]);
        else if (v < WIDE_MIN)
            return sample_t'(WIDE_MIN[SAMPLE_W-1:0]);
        else
            return sample_t'(v[SAMPLE_W-1:0]);
    endfunction

endpackage

// File: rtl/cond_hpf.sv
module cond_hpf
    import meter_cond_pkg::*;
#(
    parameter int SHIFT = 9,
    parameter int FRAC  = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    enable,
    input  sample_t x,
    output sample_t y
);
    localparam int DW = SAMPLE_W + 1;
    localparam int SW = SAMPLE_W + FRAC + 3;

    typedef logic signed [SW-1:0] state_t;

    sample_t               x_prev;
    state_t                st;
    state_t                st_next;
    state_t                diff_ext;
    state_t                out_shift;
    logic signed [DW-1:0]  diff;
    wide_t                 out_wide;

    always_comb begin
        diff      = {x[SAMPLE_W-1], x} - {x_prev[SAMPLE_W-1], x_prev};
        diff_ext  = {{(SW-DW){diff[DW-1]}}, diff};
        st_next   = st + (diff_ext <<< FRAC) - (st >>> SHIFT);
        out_shift = st_next >>> FRAC;
        out_wide  = {{(WIDE_W-SW){out_shift[SW-1]}}, out_shift};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_prev <= '0;
            st     <= '0;
            y      <= '0;
        end else if (step) begin
            x_prev <= x;
            if (enable) begin
                st <= st_next;
                y  <= sat_to_sample(out_wide);
            end else begin
                st <= '0;
                y  <= x;
            end
        end
    end

endmodule

// File: rtl/cond_integ.sv
module cond_integ
    import meter_cond_pkg::*;
#(
    parameter int LEAK    = 8,
    parameter bit HAS_INT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    enable,
    input  sample_t x,
    output sample_t y
);
    generate
        if (HAS_INT) begin : g_int
            localparam int AW = SAMPLE_W + 2;
            typedef logic signed [AW-1:0] acc_wide_t;

            sample_t   acc;
            sample_t   acc_next;
            acc_wide_t acc_ext;
            acc_wide_t x_ext;
            acc_wide_t sum;

            always_comb begin
                acc_ext  = {{2{acc[SAMPLE_W-1]}}, acc};
                x_ext    = {{2{x[SAMPLE_W-1]}}, x};
                sum      = acc_ext - (acc_ext >>> LEAK) + x_ext;
                acc_next = sat_to_sample({{(WIDE_W-AW){sum[AW-1]}}, sum});
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc <= '0;
                    y   <= '0;
                end else if (step) begin
                    if (enable) begin
                        acc <= acc_next;
                        y   <= acc_next;
                    end else begin
                        acc <= '0;
                        y   <= x;
                    end
                end
            end
        end else begin : g_pass
            logic unused_enable;
            assign unused_enable = enable;

            always_ff @(posedge clk) begin
                if (rst)
                    y <= '0;
                else if (step)
                    y <= x;
            end
        end
    endgenerate

endmodule

// File: rtl/meter_cond_chain.sv
module meter_cond_chain
    import meter_cond_pkg::*;
#(
    parameter int HPF_SHIFT = 9,
    parameter int HPF_FRAC  = 8,
    parameter int INT_LEAK  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_wdata,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] ia_in,
    input  logic [SAMPLE_W-1:0] ib_in,
    input  logic [SAMPLE_W-1:0] v_in,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] ia_out,
    output logic [SAMPLE_W-1:0] ib_out,
    output logic [SAMPLE_W-1:0] v_out
);
    cond_cfg_t          cfg_q;
    logic               hpf_vld;
    logic               out_vld_q;
    logic               hpf_en_w;
    logic               int_a_en_w;
    logic [NUM_CH-1:0]  int_en_vec;
    sample_t            x_arr [NUM_CH];
    sample_t            h_arr [NUM_CH];
    sample_t            y_arr [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (cfg_we)
            cfg_q <= cond_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpf_vld   <= 1'b0;
            out_vld_q <= 1'b0;
        end else begin
            hpf_vld   <= in_valid;
            out_vld_q <= hpf_vld;
        end
    end

    assign hpf_en_w   = cfg_q.hpf_en;
    assign int_a_en_w = cfg_q.int_a_en;

    always_comb begin
        int_en_vec        = '0;
        int_en_vec[CH_IA] = cfg_q.int_a_en;
        int_en_vec[CH_IB] = cfg_q.int_b_en;
    end

    assign x_arr[CH_IA] = sample_t'(ia_in);
    assign x_arr[CH_IB] = sample_t'(ib_in);
    assign x_arr[CH_V]  = sample_t'(v_in);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            cond_hpf #(
                .SHIFT (HPF_SHIFT),
                .FRAC  (HPF_FRAC)
            ) u_hpf (
                .clk    (clk),
                .rst    (rst),
                .step   (in_valid),
                .enable (cfg_q.hpf_en),
                .x      (x_arr[g]),
                .y      (h_arr[g])
            );

            cond_integ #(
                .LEAK    (INT_LEAK),
                .HAS_INT (g != CH_V)
            ) u_integ (
                .clk    (clk),
                .rst    (rst),
                .step   (hpf_vld),
                .enable (int_en_vec[g]),
                .x      (h_arr[g]),
                .y      (y_arr[g])
            );
        end
    endgenerate

    assign out_valid = out_vld_q;
    assign ia_out    = y_arr[CH_IA];
    assign ib_out    = y_arr[CH_IB];
    assign v_out     = y_arr[CH_V];

endmodule

// File: rtl/meter_cond_chain_chk.sv
module meter_cond_chain_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic        hpf_en,
    input logic        int_a_en,
    input logic [23:0] ia_in,
    input logic [23:0] v_in,
    input logic [23:0] ia_out,
    input logic [23:0] ib_out,
    input logic [23:0] v_out
);
    p_lat_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    p_lat_back_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(ia_out) && $stable(ib_out) && $stable(v_out)));

    p_v_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(hpf_en, 2)) |-> (v_out == $past(v_in, 2)));

    p_ia_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(hpf_en, 2) && !$past(int_a_en, 1)) |-> (ia_out == $past(ia_in, 2)));

endmodule

bind meter_cond_chain meter_cond_chain_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .hpf_en    (hpf_en_w),
    .int_a_en  (int_a_en_w),
    .ia_in     (ia_in),
    .v_in      (v_in),
    .ia_out    (ia_out),
    .ib_out    (ib_out),
    .v_out     (v_out)
);

// File: tb/meter_cond_chain_bench.sv
module meter_cond_chain_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = 3'b000;
    logic        in_valid = 1'b0;
    logic [23:0] ia_in = '0;
    logic [23:0] ib_in = '0;
    logic [23:0] v_in = '0;
    logic        out_valid;
    logic [23:0] ia_out;
    logic [23:0] ib_out;
    logic [23:0] v_out;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    meter_cond_chain u_meter_cond_chain (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .ia_in     (ia_in),
        .ib_in     (ib_in),
        .v_in      (v_in),
        .out_valid (out_valid),
        .ia_out    (ia_out),
        .ib_out    (ib_out),
        .v_out     (v_out)
    );

    // reference model state
    longint m_xp [3];
    longint m_hs [3];
    longint m_acc [3];
    bit     m_hpf = 1'b1;
    bit     m_ia  = 1'b0;
    bit     m_ib  = 1'b0;
    longint q_ia [$];
    longint q_ib [$];
    longint q_v [$];
    string  cur_tag  = "R3";
    string  cur_tagv = "R3";
    longint last_ia = 0, last_ib = 0, last_v = 0;
    bit     h1 = 1'b0, h2 = 1'b0;
    longint seed = 64'd12345;

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint s24(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint model_ch(input int c, input longint x);
        longint h, s, a;
        if (m_hpf) begin
            s = m_hs[c] + ((x - m_xp[c]) <<< 8) - (m_hs[c] >>> 9);
            m_hs[c] = s;
            h = sat24(s >>> 8);
        end else begin
            m_hs[c] = 0;
            h = x;
        end
        m_xp[c] = x;
        if ((c == 0 && m_ia) || (c == 1 && m_ib)) begin
            a = sat24(m_acc[c] - (m_acc[c] >>> 8) + h);
            m_acc[c] = a;
            return a;
        end
        m_acc[c] = 0;
        return h;
    endfunction

    task automatic send(input longint a, input longint b, input longint v);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        ia_in = a[23:0];
        ib_in = b[23:0];
        v_in  = v[23:0];
        q_ia.push_back(model_ch(0, a));
        q_ib.push_back(model_ch(1, b));
        q_v.push_back(model_ch(2, v));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic write_cfg(input logic [2:0] d);
        idle(4);
        @(posedge clk);
        #1;
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        m_ia  = d[0];
        m_ib  = d[1];
        m_hpf = d[2];
        idle(2);
    endtask

    function automatic longint rnd();
        seed = (seed * 64'd1103515245 + 64'd12345) & 64'h7fffffff;
        return (seed % 64'd16000000) - 64'd8000000;
    endfunction

    // monitor: reference comparison on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            h1 = 1'b0;
            h2 = 1'b0;
        end else begin
            check("R2 valid timing", longint'(out_valid), longint'(h2));
            h2 = h1;
            h1 = in_valid;
            if (out_valid) begin
                if (q_ia.size() == 0) begin
                    check("R2 unexpected output", 1, 0);
                end else begin
                    check(cur_tag,  s24(ia_out), q_ia.pop_front());
                    check(cur_tag,  s24(ib_out), q_ib.pop_front());
                    check(cur_tagv, s24(v_out),  q_v.pop_front());
                end
            end else begin
                check("R2 hold", s24(ia_out), last_ia);
                check("R2 hold", s24(ib_out), last_ib);
                check("R2 hold", s24(v_out),  last_v);
            end
            last_ia = s24(ia_out);
            last_ib = s24(ib_out);
            last_v  = s24(v_out);
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_xp[c] = 0;
            m_hs[c] = 0;
            m_acc[c] = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 ia_out", s24(ia_out), 0);
        check("R1 ib_out", s24(ib_out), 0);
        check("R1 v_out", s24(v_out), 0);

        // R3/R4: default configuration filters; constant input decays to zero
        cur_tag = "R3"; cur_tagv = "R3";
        for (int i = 0; i < 9000; i++) send(1000000, -2500000, 4000000);
        idle(4);
        tests++;
        if (last_ia > 2 || last_ia < -2 || last_ib > 2 || last_ib < -2 || last_v > 2 || last_v < -2) begin
            fails++;
            $display("FAIL R4 DC residue actual=%0d/%0d/%0d expected=within 2", last_ia, last_ib, last_v);
        end

        // R3: full-scale alternation reaches the output clamp
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 0) send(8388607, -8388608, 8388607);
            else            send(-8388608, 8388607, -8388608);
        end
        // R2: sparse valid patterns
        for (int i = 0; i < 20; i++) begin
            send(rnd(), rnd(), rnd());
            idle(i % 4);
        end
        idle(4);

        // R5: filter bypass passes pseudo-random data untouched
        write_cfg(3'b000);
        cur_tag = "R5"; cur_tagv = "R5";
        for (int i = 0; i < 60; i++) send(rnd(), rnd(), rnd());
        idle(4);

        // R6/R10: phase integrator only
        write_cfg(3'b001);
        cur_tag = "R6"; cur_tagv = "R10";
        for (int i = 0; i < 300; i++) send(1000, 700, 5000);
        idle(4);
        check("R10 v not integrated", last_v, 5000);
        check("R6 ib untouched by bit 0", last_ib, 700);

        // R7: neutral integrator only
        write_cfg(3'b010);
        cur_tag = "R7";
        send(100, 100, 100);
        idle(4);
        check("R9 ia restarts cleared", last_ia, 100);
        check("R7 ib integrates first sample", last_ib, 100);
        for (int i = 0; i < 200; i++) send(-3000, -3000, -3000);
        idle(4);
        check("R7 ia passes", last_ia, -3000);

        // R8: both rails saturate
        write_cfg(3'b011);
        cur_tag = "R8"; cur_tagv = "R10";
        for (int i = 0; i < 20; i++) send(8000000, 8000000, 8000000);
        idle(4);
        check("R8 ia upper rail", last_ia, 8388607);
        check("R8 ib upper rail", last_ib, 8388607);
        check("R10 v under both bits", last_v, 8000000);
        for (int i = 0; i < 40; i++) send(-8000000, -8000000, -8000000);
        idle(4);
        check("R8 ia lower rail", last_ia, -8388608);
        check("R8 ib lower rail", last_ib, -8388608);

        // R9: integrators off, filter back on; then re-enable from cleared state
        write_cfg(3'b100);
        cur_tag = "R9"; cur_tagv = "R9";
        for (int i = 0; i < 50; i++) send(rnd(), rnd(), rnd());
        idle(4);
        write_cfg(3'b000);
        send(1234, -1234, 77);
        idle(4);
        check("R9 ia pass", last_ia, 1234);
        check("R9 ib pass", last_ib, -1234);
        write_cfg(3'b011);
        send(50, -60, 70);
        idle(4);
        check("R9 ia cleared acc", last_ia, 50);
        check("R9 ib cleared acc", last_ib, -60);

        check("R2 queue drained", longint'(q_ia.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule